// File: doc/BRIEF.md
# Flash Configuration Load Sequencer

After every system reset this block walks a fixed list of words in a non-volatile array. It fetches them one per handshake and fills the module's configuration registers. These are a parameterised number of configuration words, a main-array protection word, a data-array protection word, an option word and a security word. The array side is abstract. The block raises a read request with a word address. The array answers with `arrReady` and presents the data, together with a corrected-error flag, an uncorrectable-error flag and a generic load-error flag.

CPU access is released in two steps. While the configuration words are being fetched, the CPU is stalled. Reads are then allowed while protection, option and security are fetched. Only after a final check cycle does the command-complete flag rise and permit commands. If any fetched word carried an uncorrectable fault or a load error, the check cycle replaces every register with built-in defaults: protection fully enabled and the memory secured. An uncorrectable fault also sets both bits of the two-bit fault status. A corrected single-bit error only sets a correction flag.

The block also tracks a launched command until the array reports it finished. An asynchronous reset drops that command at once and restarts the load.

Top module: `flash_init_seq`

## Requirements
- R1: While `rstN` is low, `ccif`=0, `cpuHold`=1, `readEn`=0, `cmdBusy`=0, `protMain`/`protData`/`optReg`/`secReg` are all ones, every configuration word equals `CFG_DEFAULT`, and `errStat`=0 and `corrFlag`=0.
- R2: After reset no request is made until `arrReady` is seen high once. Then `rdReq` is held and words are fetched at `BASE_ADDR+0` upward, one word per cycle in which `rdReq` and `arrReady` are both high. The order is configuration words (index 0..CFG_WORDS-1), main protection, data protection, option, security.
- R3: `cpuHold`=1 and `readEn`=0 from reset until the handshake of the last configuration word. From the next cycle `cpuHold`=0 and `readEn`=1 until the next reset.
- R4: `ccif` stays 0 throughout the load. It is 0 in the cycle after the security-word handshake and 1 in the cycle after that.
- R5: With no error flags, the registers hold exactly the fetched words when `ccif` rises.
- R6: A load error on any word makes all registers take their defaults (configuration = `CFG_DEFAULT`, protection, option and security all ones) when `ccif` rises, and leaves `errStat` unchanged.
- R7: An uncorrectable fault on any word gives the same defaults as R6 and sets `errStat`=2'b11.
- R8: A corrected error on any word, without any other error, keeps the fetched values and sets `corrFlag`=1.
- R9: `secured`=0 only when `secReg[1:0]`=2'b10. Every other encoding is secured.
- R10: `cmdLaunch` sampled while `ccif`=1 makes `cmdBusy`=1 and `ccif`=0 in the next cycle. `cmdDone` while busy gives `cmdBusy`=0 and `ccif`=1 in the next cycle. `cmdLaunch` while `ccif`=0 has no effect.
- R11: Taking `rstN` low during a command clears `cmdBusy` and `ccif` at once, without a clock edge, and the next release restarts the full load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| arrReady | input | 1 | Array ready / read handshake |
| rdData | input | DATA_W | Word returned by the array |
| rdEccSingle | input | 1 | Returned word had a corrected error |
| rdEccDouble | input | 1 | Returned word had an uncorrectable fault |
| rdLoadErr | input | 1 | Returned word had a load error |
| rdReq | output | 1 | Read request to the array |
| rdAddr | output | ADDR_W | Word address of the request |
| cpuHold | output | 1 | CPU accesses stalled |
| readEn | output | 1 | CPU flash reads allowed |
| ccif | output | 1 | Command complete / ready for commands |
| cmdLaunch | input | 1 | Launch a command |
| cmdDone | input | 1 | Array reports command finished |
| cmdBusy | output | 1 | A command is in progress |
| cfgWords | output | CFG_WORDS*DATA_W | Configuration words, word 0 in the low bits |
| protMain | output | DATA_W | Main-array protection register |
| protData | output | DATA_W | Data-array protection register |
| optReg | output | DATA_W | Option register |
| secReg | output | DATA_W | Security register |
| secured | output | 1 | Security state decoded from secReg[1:0] |
| errStat | output | 2 | Uncorrectable-fault status |
| corrFlag | output | 1 | Corrected-error flag |

## Verification
The bench builds the block with three configuration words, a base address of 8'h40 and a non-zero configuration default of 16'hA5C3. The odd count moves the hold-release point off an even word index and makes the sequence seven fetches long. The non-zero default lets a fallback be told apart from fetched zeros. The offset base checks the address arithmetic rather than a bare index. Random array stalls, random data and random error placement are mixed with directed error injections on the first and last word and with both security encodings.

// File: rtl/flash_init_pkg.sv
package flash_init_pkg;

  typedef enum logic [2:0] {
    RESET_HOLD,
    LOAD_CFG,
    LOAD_PROT,
    LOAD_OPT_SEC,
    CHECK,
    DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;        // store rdData into the register picked by wordIdx
    logic applyDefaults;  // overwrite every register with its safe default
  } seqStrobe_t;

  localparam logic [1:0] SEC_OPEN_CODE  = 2'b10;
  localparam logic [1:0] ERR_DOUBLE_HIT = 2'b11;

endpackage

// File: rtl/fis_seq_ctrl.sv
module fis_seq_ctrl
  import flash_init_pkg::*;
#(
  parameter int              CFG_WORDS = 2,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               arrReady,
  input  logic               errSeen,
  input  logic               cmdLaunch,
  input  logic               cmdDone,
  output seqStrobe_t         strobe,
  output logic [$clog2(CFG_WORDS+4)-1:0] wordIdx,
  output logic               rdReq,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic               cpuHold,
  output logic               readEn,
  output logic               ccif,
  output logic               cmdBusy
);

  localparam int TOTAL = CFG_WORDS + 4;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_CFG  = IDX_W'(CFG_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_PROT = IDX_W'(CFG_WORDS + 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(TOTAL - 1);

  seqState_t stateQ, stateD;
  logic [IDX_W-1:0] idxQ;
  logic handshake;

  assign rdReq     = (stateQ == LOAD_CFG) || (stateQ == LOAD_PROT) ||
                     (stateQ == LOAD_OPT_SEC);
  assign handshake = rdReq && arrReady;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      RESET_HOLD:   if (arrReady) stateD = LOAD_CFG;
      LOAD_CFG:     if (handshake && idxQ == LAST_CFG)  stateD = LOAD_PROT;
      LOAD_PROT:    if (handshake && idxQ == LAST_PROT) stateD = LOAD_OPT_SEC;
      LOAD_OPT_SEC: if (handshake && idxQ == LAST_WORD) stateD = CHECK;
      CHECK:        stateD = DONE;
      DONE:         stateD = DONE;
      default:      stateD = RESET_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= RESET_HOLD;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      if (handshake && idxQ != LAST_WORD) idxQ <= idxQ + 1'b1;
    end
  end

  // command tracking; reset drops a running command immediately
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cmdBusy <= 1'b0;
    else if (ccif && cmdLaunch) cmdBusy <= 1'b1;
    else if (cmdBusy && cmdDone) cmdBusy <= 1'b0;
  end

  assign cpuHold = (stateQ == RESET_HOLD) || (stateQ == LOAD_CFG);
  assign readEn  = !cpuHold;
  assign ccif    = (stateQ == DONE) && !cmdBusy;
  assign rdAddr  = BASE_ADDR + ADDR_W'(idxQ);
  assign wordIdx = idxQ;

  assign strobe.capture       = handshake;
  assign strobe.applyDefaults = (stateQ == CHECK) && errSeen;

endmodule

// File: rtl/fis_cfg_datapath.sv
module fis_cfg_datapath
  import flash_init_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                CFG_WORDS   = 2,
  parameter logic [DATA_W-1:0] CFG_DEFAULT = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobe_t                  strobe,
  input  logic [$clog2(CFG_WORDS+4)-1:0] wordIdx,
  input  logic [DATA_W-1:0]           rdData,
  input  logic                        rdEccSingle,
  input  logic                        rdEccDouble,
  input  logic                        rdLoadErr,
  output logic [CFG_WORDS*DATA_W-1:0] cfgWords,
  output logic [DATA_W-1:0]           protMain,
  output logic [DATA_W-1:0]           protData,
  output logic [DATA_W-1:0]           optReg,
  output logic [DATA_W-1:0]           secReg,
  output logic [1:0]                  errStat,
  output logic                        corrFlag,
  output logic                        errSeen
);

  localparam int IDX_W = $clog2(CFG_WORDS + 4);
  localparam logic [IDX_W-1:0] IDX_PMAIN = IDX_W'(CFG_WORDS);
  localparam logic [IDX_W-1:0] IDX_PDATA = IDX_W'(CFG_WORDS + 1);
  localparam logic [IDX_W-1:0] IDX_OPT   = IDX_W'(CFG_WORDS + 2);
  localparam logic [IDX_W-1:0] IDX_SEC   = IDX_W'(CFG_WORDS + 3);
  localparam logic [DATA_W-1:0] SAFE_ONES = '1;

  for (genvar g = 0; g < CFG_WORDS; g++) begin : gCfg
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       wordQ <= CFG_DEFAULT;
      else if (strobe.applyDefaults)                   wordQ <= CFG_DEFAULT;
      else if (strobe.capture && wordIdx == IDX_W'(g)) wordQ <= rdData;
    end
    assign cfgWords[g*DATA_W +: DATA_W] = wordQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protMain <= SAFE_ONES;
      protData <= SAFE_ONES;
      optReg   <= SAFE_ONES;
      secReg   <= SAFE_ONES;
    end else if (strobe.applyDefaults) begin
      protMain <= SAFE_ONES;
      protData <= SAFE_ONES;
      optReg   <= SAFE_ONES;
      secReg   <= SAFE_ONES;
    end else if (strobe.capture) begin
      if (wordIdx == IDX_PMAIN) protMain <= rdData;
      if (wordIdx == IDX_PDATA) protData <= rdData;
      if (wordIdx == IDX_OPT)   optReg   <= rdData;
      if (wordIdx == IDX_SEC)   secReg   <= rdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errStat  <= '0;
      corrFlag <= 1'b0;
      errSeen  <= 1'b0;
    end else if (strobe.capture) begin
      if (rdEccDouble)              errStat  <= ERR_DOUBLE_HIT;
      if (rdEccSingle)              corrFlag <= 1'b1;
      if (rdEccDouble || rdLoadErr) errSeen  <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_init_seq.sv
module flash_init_seq
  import flash_init_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                CFG_WORDS   = 2,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = '0,
  parameter logic [DATA_W-1:0] CFG_DEFAULT = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        arrReady,
  input  logic [DATA_W-1:0]           rdData,
  input  logic                        rdEccSingle,
  input  logic                        rdEccDouble,
  input  logic                        rdLoadErr,
  output logic                        rdReq,
  output logic [ADDR_W-1:0]           rdAddr,
  output logic                        cpuHold,
  output logic                        readEn,
  output logic                        ccif,
  input  logic                        cmdLaunch,
  input  logic                        cmdDone,
  output logic                        cmdBusy,
  output logic [CFG_WORDS*DATA_W-1:0] cfgWords,
  output logic [DATA_W-1:0]           protMain,
  output logic [DATA_W-1:0]           protData,
  output logic [DATA_W-1:0]           optReg,
  output logic [DATA_W-1:0]           secReg,
  output logic                        secured,
  output logic [1:0]                  errStat,
  output logic                        corrFlag
);

  localparam int IDX_W = $clog2(CFG_WORDS + 4);

  seqStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             errSeen;

  fis_seq_ctrl #(
    .CFG_WORDS(CFG_WORDS), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .arrReady(arrReady), .errSeen(errSeen),
    .cmdLaunch(cmdLaunch), .cmdDone(cmdDone), .strobe(strobe),
    .wordIdx(wordIdx), .rdReq(rdReq), .rdAddr(rdAddr), .cpuHold(cpuHold),
    .readEn(readEn), .ccif(ccif), .cmdBusy(cmdBusy)
  );

  fis_cfg_datapath #(
    .DATA_W(DATA_W), .CFG_WORDS(CFG_WORDS), .CFG_DEFAULT(CFG_DEFAULT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx),
    .rdData(rdData), .rdEccSingle(rdEccSingle), .rdEccDouble(rdEccDouble),
    .rdLoadErr(rdLoadErr), .cfgWords(cfgWords), .protMain(protMain),
    .protData(protData), .optReg(optReg), .secReg(secReg),
    .errStat(errStat), .corrFlag(corrFlag), .errSeen(errSeen)
  );

  assign secured = (secReg[1:0] != SEC_OPEN_CODE);

endmodule

// File: rtl/flash_init_seq_chk.sv
module flash_init_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              arrReady,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              cpuHold,
  input logic              readEn,
  input logic              ccif,
  input logic              cmdLaunch,
  input logic              cmdDone,
  input logic              cmdBusy,
  input logic [DATA_W-1:0] protMain,
  input logic              secured,
  input logic [1:0]        errStat
);

  // R2: each handshake moves the address on by exactly one word
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && arrReady) |=> (!rdReq || rdAddr == $past(rdAddr) + ADDR_W'(1)));

  // R3: stall and read release never overlap
  a_r3_hold_excl: assert property (@(posedge clk) disable iff (!rstN)
    cpuHold |-> !readEn);

  // R3: once reads are released they stay released
  a_r3_release_stays: assert property (@(posedge clk) disable iff (!rstN)
    readEn |=> readEn);

  // R4: no command readiness while fetching or stalled
  a_r4_ccif_low_load: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq || cpuHold) |-> !ccif);

  // R7: an uncorrectable fault always ends protected and secured
  a_r7_double_safe: assert property (@(posedge clk) disable iff (!rstN)
    (ccif && errStat == 2'b11) |-> (protMain == '1 && secured));

  // R10: accepted launch
  a_r10_launch: assert property (@(posedge clk) disable iff (!rstN)
    (ccif && cmdLaunch) |=> (cmdBusy && !ccif));

  // R10: completion
  a_r10_done: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBusy && cmdDone) |=> (!cmdBusy && ccif));

  // R10: launch without readiness is ignored
  a_r10_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!ccif && !cmdBusy && cmdLaunch) |=> !cmdBusy);

endmodule

bind flash_init_seq flash_init_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .arrReady(arrReady), .rdReq(rdReq), .rdAddr(rdAddr),
  .cpuHold(cpuHold), .readEn(readEn), .ccif(ccif), .cmdLaunch(cmdLaunch),
  .cmdDone(cmdDone), .cmdBusy(cmdBusy), .protMain(protMain),
  .secured(secured), .errStat(errStat)
);

// File: tb/test_flash_init_seq.sv
module test_flash_init_seq;

  localparam int              CLK_PERIOD  = 10;
  localparam int              DATA_W      = 16;
  localparam int              CFG_WORDS   = 3;
  localparam int              ADDR_W      = 8;
  localparam logic [7:0]      BASE_ADDR   = 8'h40;
  localparam logic [15:0]     CFG_DEFAULT = 16'hA5C3;
  localparam int              TOTAL       = CFG_WORDS + 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arrReady = 1'b0;
  logic [DATA_W-1:0] rdData = '0;
  logic rdEccSingle = 1'b0, rdEccDouble = 1'b0, rdLoadErr = 1'b0;
  logic cmdLaunch = 1'b0, cmdDone = 1'b0;
  logic rdReq, cpuHold, readEn, ccif, cmdBusy, secured, corrFlag;
  logic [ADDR_W-1:0] rdAddr;
  logic [CFG_WORDS*DATA_W-1:0] cfgWords;
  logic [DATA_W-1:0] protMain, protData, optReg, secReg;
  logic [1:0] errStat;

  flash_init_seq #(
    .DATA_W(DATA_W), .CFG_WORDS(CFG_WORDS), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .CFG_DEFAULT(CFG_DEFAULT)
  ) i_flash_init_seq (
    .clk(clk), .rstN(rstN), .arrReady(arrReady), .rdData(rdData),
    .rdEccSingle(rdEccSingle), .rdEccDouble(rdEccDouble), .rdLoadErr(rdLoadErr),
    .rdReq(rdReq), .rdAddr(rdAddr), .cpuHold(cpuHold), .readEn(readEn),
    .ccif(ccif), .cmdLaunch(cmdLaunch), .cmdDone(cmdDone), .cmdBusy(cmdBusy),
    .cfgWords(cfgWords), .protMain(protMain), .protData(protData),
    .optReg(optReg), .secReg(secReg), .secured(secured), .errStat(errStat),
    .corrFlag(corrFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nTests = 0;
  int nFail  = 0;

  logic [DATA_W-1:0] memData [TOTAL];
  bit memSbe [TOTAL];
  bit memDbe [TOTAL];
  bit memLerr [TOTAL];

  task automatic check(bit ok, string req, string what,
                       longint unsigned act, longint unsigned exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 clean, 1 corrected, 2 uncorrectable, 3 load error
  task automatic fillArray(int kind, int where, int secCode);
    for (int i = 0; i < TOTAL; i++) begin
      memData[i] = DATA_W'($urandom);
      memSbe[i] = 0; memDbe[i] = 0; memLerr[i] = 0;
    end
    memData[TOTAL-1][1:0] = 2'(secCode);
    case (kind)
      1: memSbe[where] = 1;
      2: memDbe[where] = 1;
      3: memLerr[where] = 1;
      default: ;
    endcase
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; arrReady = 1'b0; cmdLaunch = 1'b0; cmdDone = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // runs one full load and checks sequencing and resulting register values
  task automatic runLoad(bit launchNoise);
    int expIdx = 0;
    int since = -1;
    int orderBad = 0, holdBad = 0, ccifBad = 0, guard = 0;
    bit doneFlag = 0;
    bit anyFail = 0, anyDbe = 0, anySbe = 0;
    logic [DATA_W-1:0] expW;
    doReset();
    while (!doneFlag && guard < 3000) begin
      guard++;
      if (since >= 0) since++;
      if (since < 0 && ccif) ccifBad++;
      if (since == 1 && ccif) ccifBad++;
      if (since == 2) begin
        if (!ccif) ccifBad++;
        doneFlag = 1;
      end
      if (rdReq) begin
        if (rdAddr != BASE_ADDR + ADDR_W'(expIdx)) orderBad++;
        if (expIdx < CFG_WORDS) begin
          if (!cpuHold || readEn) holdBad++;
        end else if (cpuHold || !readEn) holdBad++;
      end
      if (!doneFlag) begin
        arrReady  = ($urandom % 4) != 0;
        cmdLaunch = launchNoise ? 1'($urandom % 2) : 1'b0;
        if (rdReq && expIdx < TOTAL) begin
          rdData = memData[expIdx]; rdEccSingle = memSbe[expIdx];
          rdEccDouble = memDbe[expIdx]; rdLoadErr = memLerr[expIdx];
        end else begin
          rdData = DATA_W'($urandom); rdEccSingle = 0; rdEccDouble = 0; rdLoadErr = 0;
        end
        if (rdReq && arrReady && expIdx < TOTAL) begin
          expIdx++;
          if (expIdx == TOTAL) since = 0;
        end
        @(negedge clk);
      end
    end
    cmdLaunch = 1'b0; arrReady = 1'b0;
    rdEccSingle = 0; rdEccDouble = 0; rdLoadErr = 0;
    check(orderBad == 0 && expIdx == TOTAL, "R2", "fetch order errors", orderBad, 0);
    check(holdBad == 0, "R3", "hold/read release errors", holdBad, 0);
    check(ccifBad == 0 && doneFlag, "R4", "ccif timing errors", ccifBad, 0);
    for (int i = 0; i < TOTAL; i++) begin
      anyFail |= memDbe[i] | memLerr[i];
      anyDbe  |= memDbe[i];
      anySbe  |= memSbe[i];
    end
    for (int g = 0; g < CFG_WORDS; g++) begin
      expW = anyFail ? CFG_DEFAULT : memData[g];
      check(cfgWords[g*DATA_W +: DATA_W] == expW, anyFail ? "R6/R7" : "R5",
            "config word", cfgWords[g*DATA_W +: DATA_W], expW);
    end
    expW = anyFail ? '1 : memData[CFG_WORDS];
    check(protMain == expW, anyFail ? "R6/R7" : "R5", "protMain", protMain, expW);
    expW = anyFail ? '1 : memData[CFG_WORDS+1];
    check(protData == expW, anyFail ? "R6/R7" : "R5", "protData", protData, expW);
    expW = anyFail ? '1 : memData[CFG_WORDS+2];
    check(optReg == expW, anyFail ? "R6/R7" : "R5", "optReg", optReg, expW);
    expW = anyFail ? '1 : memData[CFG_WORDS+3];
    check(secReg == expW, anyFail ? "R6/R7" : "R5", "secReg", secReg, expW);
    check(secured == (expW[1:0] != 2'b10), "R9", "secured", secured, expW[1:0] != 2'b10);
    check(errStat == (anyDbe ? 2'b11 : 2'b00), "R7", "errStat", errStat, anyDbe ? 3 : 0);
    check(corrFlag == anySbe, "R8", "corrFlag", corrFlag, anySbe);
    if (launchNoise)
      check(!cmdBusy && ccif, "R10", "launch during load ignored", cmdBusy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4711));
    // R1 reset state
    repeat (2) @(negedge clk);
    check(!ccif && cpuHold && !readEn && !cmdBusy, "R1", "status in reset",
          {ccif, cpuHold, readEn, cmdBusy}, 4'b0100);
    check(protMain == '1 && protData == '1 && optReg == '1 && secReg == '1 && secured,
          "R1", "protection/security in reset", protMain, 16'hFFFF);
    check(cfgWords == {CFG_WORDS{CFG_DEFAULT}}, "R1", "config in reset",
          cfgWords, {CFG_WORDS{CFG_DEFAULT}});
    check(errStat == 0 && !corrFlag, "R1", "flags in reset", errStat, 0);

    // directed corners
    fillArray(0, 0, 2);             runLoad(0);   // R9 open encoding, R5
    fillArray(0, 0, 1);             runLoad(0);   // R9 secured encoding
    fillArray(2, TOTAL-1, 2);       runLoad(0);   // R7 fault on last word
    fillArray(3, 0, 2);             runLoad(0);   // R6 error on first word
    fillArray(1, CFG_WORDS, 2);     runLoad(1);   // R8 corrected, R10 ignore

    // R10 command accept and completion
    @(negedge clk); cmdLaunch = 1'b1;
    @(negedge clk); cmdLaunch = 1'b0;
    check(cmdBusy && !ccif, "R10", "busy after launch", {cmdBusy, ccif}, 2'b10);
    repeat (3) @(negedge clk);
    check(cmdBusy && !ccif, "R10", "busy held", {cmdBusy, ccif}, 2'b10);
    cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
    check(!cmdBusy && ccif, "R10", "ready after done", {cmdBusy, ccif}, 2'b01);

    // R11 reset aborts a running command
    cmdLaunch = 1'b1;
    @(negedge clk); cmdLaunch = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    #1;
    check(!cmdBusy && !ccif && cpuHold, "R11", "abort on reset",
          {cmdBusy, ccif, cpuHold}, 3'b001);
    fillArray(0, 0, 3);             runLoad(0);   // R11 restart loads again

    // constrained random mix
    for (int n = 0; n < 14; n++) begin
      fillArray(int'($urandom % 4), int'($urandom % TOTAL), int'($urandom % 4));
      runLoad(1'($urandom % 2));
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule